// File: doc/BRIEF.md
# General-Purpose Event and PCI Slot Hotplug Notifier

This block holds a small general-purpose event register file and reports PCI slot insert and remove events. Software reaches it through byte-addressed accesses on a simple synchronous port. The 16-bit event status register and the 16-bit event enable register are each reached as two bytes. Status bits are cleared by writing ones. Enable bytes are written directly.

A separate eight-byte slot window shows two 32-bit bitmaps. One names the slot that was most recently inserted and the other names the slot that was most recently removed. A four-byte eject register takes a slot mask. Writing it issues a one-cycle eject strobe carrying the index of the lowest set bit of the mask.

Hotplug requests arrive on a dedicated request input with a slot number and a direction. Each request clears both bitmaps, records the slot in the bitmap for its direction and raises the hotplug bit of the event status. When the hotplug enable bit was set in the cycle of the request, the block also emits a one-cycle interrupt pulse. Bus protocol decoding happens upstream of this block.

Top module: `gpe_hotplug_ctrl`

## Requirements
- R1: After reset, event status, event enable, both slot bitmaps, the interrupt pulse and the eject strobe are all zero.
- R2: Reads in the event block return one byte in `bus_rdata[7:0]` with bits 31:8 zero. Address 0xAFE0 gives status bits 7:0 and 0xAFE1 gives status bits 15:8. Address 0xAFE2 gives enable bits 7:0 and 0xAFE3 gives enable bits 15:8.
- R3: A write to a status byte (0xAFE0 or 0xAFE1) clears exactly the bits of that byte that are 1 in `bus_wdata[7:0]`. It leaves all other status bits unchanged.
- R4: A write to an enable byte (0xAFE2 or 0xAFE3) replaces that byte with `bus_wdata[7:0]` and leaves the other enable byte unchanged.
- R5: In the cycle after a hotplug request, both bitmaps hold zero except for bit `hp_slot`. That bit is set in the inserted bitmap when `hp_insert`=1, and in the removed bitmap otherwise. Status bit 1 is set in the same cycle.
- R6: `irq_pulse` is high for exactly the one cycle after a hotplug request, and only if enable bit 1 held 1 in the request cycle. An enable write in that same cycle does not affect the pulse.
- R7: Reads at 0xAE00..0xAE03 return the inserted bitmap and reads at 0xAE04..0xAE07 return the removed bitmap. In both, bit n stands for slot n. Writes to this window have no effect.
- R8: Reads at 0xAE08..0xAE0B return 0.
- R9: A write of a nonzero value V to 0xAE08..0xAE0B raises `eject_strobe` for exactly the next cycle. In that cycle `eject_slot` equals the index of the lowest set bit of V.
- R10: A write of zero to the eject register produces no strobe.
- R11: When a hotplug request and a status write clearing bit 1 occur in the same cycle, status bit 1 ends up set.
- R12: Reads of any other address return 0, and writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data (event bytes use bits 7:0) |
| bus_rdata | output | 32 | Combinational read data for the current read |
| hp_req | input | 1 | Hotplug event request, one cycle |
| hp_insert | input | 1 | 1 = slot inserted, 0 = slot removed |
| hp_slot | input | 5 | Slot number of the event |
| irq_pulse | output | 1 | One-cycle event interrupt |
| eject_strobe | output | 1 | One-cycle eject command |
| eject_slot | output | 5 | Slot to eject, valid with the strobe |

## Verification
Assertions check several properties on every cycle:
- status bits rise only through a hotplug request;
- enable bits change only through an enable write;
- the two bitmaps together never hold more than one set bit;
- every interrupt pulse follows a request made with the hotplug enable bit set;
- every eject strobe names the lowest set bit of the value written one cycle earlier;
- a zero eject write stays quiet.

Only the bench's scenarios can show the byte-lane placement of reads and the effect of a write-one-to-clear on the other byte. They also cover the priority of a hotplug over a same-cycle clear, the use of the pre-write enable value, and that writes to the slot window and to unmapped addresses are ignored.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_EVT   = 2'd1,
    RGN_SLOT  = 2'd2,
    RGN_EJECT = 2'd3
  } gpe_region_e;

  // write-one-to-clear on one byte
  function automatic logic [7:0] w1c_byte(input logic [7:0] cur, input logic [7:0] clr);
    return cur & ~clr;
  endfunction

endpackage

// File: rtl/gpe_event_regs.sv
module gpe_event_regs #(
  parameter int EVT_W  = 16,
  parameter int HP_BIT = 1,
  localparam int NBYTES = EVT_W / 8,
  localparam int BIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_is_en,
  input  logic [BIDX_W-1:0] wr_byte,
  input  logic [7:0]        wr_data,
  input  logic              hp_fire,
  input  logic              rd_is_en,
  input  logic [BIDX_W-1:0] rd_byte,
  output logic [7:0]        rd_data,
  output logic              sci_pulse
);

  logic [EVT_W-1:0]  sts_q, en_q;
  logic [EVT_W-1:0]  sts_cleared, en_written, sts_d;
  logic [NBYTES-1:0] lane_hit;
  logic              sci_q;

  function automatic logic [7:0] pick_lane(input logic [EVT_W-1:0] v, input logic [BIDX_W-1:0] idx);
    return v[idx*8 +: 8];
  endfunction

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane_hit[b] = wr_en && (wr_byte == BIDX_W'(b));
    assign sts_cleared[b*8 +: 8] = (lane_hit[b] && !wr_is_en)
                                   ? gpe_pkg::w1c_byte(sts_q[b*8 +: 8], wr_data)
                                   : sts_q[b*8 +: 8];
    assign en_written[b*8 +: 8]  = (lane_hit[b] && wr_is_en) ? wr_data : en_q[b*8 +: 8];
  end

  // hotplug set takes priority over a same-cycle clear
  always_comb begin
    sts_d = sts_cleared;
    if (hp_fire) sts_d[HP_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      sci_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_written;
      sci_q <= hp_fire && en_q[HP_BIT];
    end
  end

  assign rd_data   = pick_lane(rd_is_en ? en_q : sts_q, rd_byte);
  assign sci_pulse = sci_q;

  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_fire |=> ((sts_q & ~$past(sts_q)) == '0));
  a_r4_enable_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_is_en) |=> $stable(en_q));
  a_r11_hotplug_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hp_fire |=> sts_q[HP_BIT]);
  a_r6_pulse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    sci_pulse |-> ($past(hp_fire) && $past(en_q[HP_BIT])));
  a_r6_enabled_event_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_fire && en_q[HP_BIT]) |=> sci_pulse);

endmodule

// File: rtl/gpe_slot_status.sv
module gpe_slot_status #(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hp_fire,
  input  logic              hp_insert,
  input  logic [SLOT_W-1:0] hp_slot,
  input  logic              rd_removed,
  output logic [DATA_W-1:0] rd_word
);

  logic [NUM_SLOTS-1:0] ins_q, rem_q;

  function automatic logic [NUM_SLOTS-1:0] slot_mask(input logic [SLOT_W-1:0] s);
    logic [NUM_SLOTS-1:0] m;
    m = '0;
    m[s] = 1'b1;
    return m;
  endfunction

  // each event clears both maps before recording its slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_q <= '0;
      rem_q <= '0;
    end else if (hp_fire) begin
      ins_q <= hp_insert  ? slot_mask(hp_slot) : '0;
      rem_q <= !hp_insert ? slot_mask(hp_slot) : '0;
    end
  end

  assign rd_word = DATA_W'(rd_removed ? rem_q : ins_q);

  a_r5_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ins_q, rem_q}) <= 1);
  a_r5_insert_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_fire && hp_insert) |=> ins_q[$past(hp_slot)]);
  a_r5_remove_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_fire && !hp_insert) |=> rem_q[$past(hp_slot)]);

endmodule

// File: rtl/gpe_eject_unit.sv
module gpe_eject_unit #(
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              strobe,
  output logic [IDX_W-1:0]  slot
);

  logic             stb_q;
  logic [IDX_W-1:0] slot_q;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [DATA_W-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (v[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      slot_q <= '0;
    end else begin
      stb_q <= wr_en && (wr_data != '0);
      if (wr_en && (wr_data != '0)) slot_q <= lowest_set(wr_data);
    end
  end

  assign strobe = stb_q;
  assign slot   = slot_q;

  a_r10_zero_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data == '0)) |=> !strobe);
  a_r9_strobe_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> ($past(wr_en) && ($past(wr_data) != '0)));
  a_r9_lowest_bit: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> ((($past(wr_data) >> slot) & {{(DATA_W-1){1'b0}}, 1'b1}) != '0)
           && (($past(wr_data) & (({{(DATA_W-1){1'b0}}, 1'b1} << slot) - 1'b1)) == '0));

endmodule

// File: rtl/gpe_hotplug_ctrl.sv
module gpe_hotplug_ctrl #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 32,
  parameter int          EVT_W     = 16,
  parameter int          HP_BIT    = 1,
  parameter int          NUM_SLOTS = 32,
  parameter logic [15:0] EVT_BASE  = 16'hAFE0,
  parameter logic [15:0] SLOT_BASE = 16'hAE00,
  parameter logic [15:0] EJ_BASE   = 16'hAE08,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int EJ_IDX_W = $clog2(DATA_W),
  localparam int NBYTES   = EVT_W / 8,
  localparam int BIDX_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int EVT_AW   = BIDX_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                hp_req,
  input  logic                hp_insert,
  input  logic [SLOT_W-1:0]   hp_slot,
  output logic                irq_pulse,
  output logic                eject_strobe,
  output logic [EJ_IDX_W-1:0] eject_slot
);

  gpe_pkg::gpe_region_e region;
  logic                 wr_cyc, rd_cyc;
  logic                 evt_wr, ej_wr;
  logic [7:0]           evt_rd_byte;
  logic [DATA_W-1:0]    slot_rd_word;

  // region decode: event block, slot window (8 bytes), eject (4 bytes)
  always_comb begin
    if (bus_addr[ADDR_W-1:EVT_AW] == EVT_BASE[ADDR_W-1:EVT_AW])
      region = gpe_pkg::RGN_EVT;
    else if (bus_addr[ADDR_W-1:3] == SLOT_BASE[ADDR_W-1:3])
      region = gpe_pkg::RGN_SLOT;
    else if (bus_addr[ADDR_W-1:2] == EJ_BASE[ADDR_W-1:2])
      region = gpe_pkg::RGN_EJECT;
    else
      region = gpe_pkg::RGN_NONE;
  end

  assign wr_cyc = bus_sel && bus_we;
  assign rd_cyc = bus_sel && !bus_we;
  assign evt_wr = wr_cyc && (region == gpe_pkg::RGN_EVT);
  assign ej_wr  = wr_cyc && (region == gpe_pkg::RGN_EJECT);

  gpe_event_regs #(.EVT_W(EVT_W), .HP_BIT(HP_BIT)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (evt_wr),
    .wr_is_en  (bus_addr[BIDX_W]),
    .wr_byte   (bus_addr[BIDX_W-1:0]),
    .wr_data   (bus_wdata[7:0]),
    .hp_fire   (hp_req),
    .rd_is_en  (bus_addr[BIDX_W]),
    .rd_byte   (bus_addr[BIDX_W-1:0]),
    .rd_data   (evt_rd_byte),
    .sci_pulse (irq_pulse)
  );

  gpe_slot_status #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .hp_fire    (hp_req),
    .hp_insert  (hp_insert),
    .hp_slot    (hp_slot),
    .rd_removed (bus_addr[2]),
    .rd_word    (slot_rd_word)
  );

  gpe_eject_unit #(.DATA_W(DATA_W)) u_eject (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ej_wr),
    .wr_data (bus_wdata),
    .strobe  (eject_strobe),
    .slot    (eject_slot)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_cyc) begin
      case (region)
        gpe_pkg::RGN_EVT:  bus_rdata = DATA_W'(evt_rd_byte);
        gpe_pkg::RGN_SLOT: bus_rdata = slot_rd_word;
        default:           bus_rdata = '0;
      endcase
    end
  end

  a_r8_eject_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && (region == gpe_pkg::RGN_EJECT)) |-> (bus_rdata == '0));
  a_r2_event_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && (region == gpe_pkg::RGN_EVT)) |-> (bus_rdata[DATA_W-1:8] == '0));

endmodule

// File: tb/gpe_hotplug_ctrl_test.sv
`timescale 1ns/1ps
module gpe_hotplug_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hp_req = 1'b0, hp_insert = 1'b0;
  logic [4:0]  hp_slot = '0;
  logic        irq_pulse, eject_strobe;
  logic [4:0]  eject_slot;

  always #2.5 clk = ~clk;

  gpe_hotplug_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hp_req(hp_req), .hp_insert(hp_insert), .hp_slot(hp_slot),
    .irq_pulse(irq_pulse), .eject_strobe(eject_strobe), .eject_slot(eject_slot)
  );

  int checks = 0, failures = 0;
  int irq_count = 0, eject_count = 0, last_eject = -1;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_sts, m_en;
  logic [31:0] m_ins, m_rem;
  bit  m_irq, m_stb, started;
  int  m_slot;

  function automatic int first_one(input logic [31:0] v);
    int i = 0;
    while (i < 32 && v[i] == 1'b0) i++;
    return i;
  endfunction

  function automatic logic [31:0] model_read(input int a);
    if (!(bus_sel && !bus_we)) return 0;
    if (a == 'hAFE0) return m_sts % 256;
    if (a == 'hAFE1) return m_sts / 256;
    if (a == 'hAFE2) return m_en % 256;
    if (a == 'hAFE3) return m_en / 256;
    if (a >= 'hAE00 && a < 'hAE04) return m_ins;
    if (a >= 'hAE04 && a < 'hAE08) return m_rem;
    return 0;
  endfunction

  function automatic string region_tag(input int a);
    if (a >= 'hAFE0 && a <= 'hAFE3) return "R2 event read";
    if (a >= 'hAE00 && a <= 'hAE07) return "R7 slot read";
    if (a >= 'hAE08 && a <= 'hAE0B) return "R8 eject read";
    return "R12 unmapped read";
  endfunction

  always @(posedge clk) begin
    int a, s, e;
    started <= 1'b1;
    if (!rst_n) begin
      m_sts <= 0; m_en <= 0; m_ins <= 0; m_rem <= 0; m_irq <= 0; m_stb <= 0;
    end else begin
      a = int'(bus_addr); s = m_sts; e = m_en;
      m_irq <= hp_req && ((m_en / 2) % 2 == 1);
      m_stb <= bus_sel && bus_we && a >= 'hAE08 && a <= 'hAE0B && bus_wdata != 0;
      if (bus_sel && bus_we && a >= 'hAE08 && a <= 'hAE0B && bus_wdata != 0)
        m_slot <= first_one(bus_wdata);
      if (bus_sel && bus_we) begin
        if (a == 'hAFE0) s = s & ~int'(bus_wdata[7:0]);
        if (a == 'hAFE1) s = s & ~(int'(bus_wdata[7:0]) * 256);
        if (a == 'hAFE2) e = (e / 256) * 256 + int'(bus_wdata[7:0]);
        if (a == 'hAFE3) e = (e % 256) + int'(bus_wdata[7:0]) * 256;
      end
      if (hp_req) begin
        s = s | 2;
        m_ins <= hp_insert ? (32'd1 << hp_slot) : 32'd0;
        m_rem <= hp_insert ? 32'd0 : (32'd1 << hp_slot);
      end
      m_sts <= s; m_en <= e;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R6 irq per-cycle", {31'd0, irq_pulse}, {31'd0, m_irq});
      chk("R9 strobe per-cycle", {31'd0, eject_strobe}, {31'd0, m_stb});
      if (m_stb) chk("R9 slot per-cycle", {27'd0, eject_slot}, m_slot);
      chk(region_tag(int'(bus_addr)), bus_rdata, model_read(int'(bus_addr)));
    end
    if (irq_pulse) irq_count++;
    if (eject_strobe) begin eject_count++; last_eject = int'(eject_slot); end
  end

  // ---------------- stimulus helpers ----------------
  task automatic clear_inputs();
    bus_sel = 0; bus_we = 0; bus_addr = 16'h0000; bus_wdata = 0; hp_req = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; clear_inputs(); end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(posedge clk); #1; clear_inputs();
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic hp(input logic ins, input logic [4:0] s);
    @(posedge clk); #1; clear_inputs();
    hp_req = 1; hp_insert = ins; hp_slot = s;
  endtask

  task automatic rd_expect(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1; clear_inputs();
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    idle(3);
    rst_n = 1;
    rd_expect(16'hAFE0, 32'h0, "R1 status lo after reset");
    rd_expect(16'hAFE3, 32'h0, "R1 enable hi after reset");
    rd_expect(16'hAE00, 32'h0, "R1 inserted map after reset");
    rd_expect(16'hAE04, 32'h0, "R1 removed map after reset");
    chk("R1 no irq after reset", irq_count, 0);

    wr(16'hAFE2, 32'h02);
    rd_expect(16'hAFE2, 32'h02, "R4 enable lo written");
    wr(16'hAFE3, 32'hA5);
    rd_expect(16'hAFE3, 32'hA5, "R4 enable hi written");
    rd_expect(16'hAFE2, 32'h02, "R4 enable lo kept");

    hp(1'b1, 5'd5);
    idle(2);
    chk("R6 irq on enabled insert", irq_count, 1);
    rd_expect(16'hAFE0, 32'h02, "R5 status bit1 set");
    rd_expect(16'hAE00, 32'h20, "R5 inserted slot 5");
    rd_expect(16'hAE04, 32'h0, "R5 removed map clear");

    hp(1'b0, 5'd31);
    idle(2);
    chk("R6 irq on enabled remove", irq_count, 2);
    rd_expect(16'hAE00, 32'h0, "R5 inserted cleared by remove");
    rd_expect(16'hAE07, 32'h80000000, "R5 removed slot 31");

    wr(16'hAFE0, 32'h00);
    rd_expect(16'hAFE0, 32'h02, "R3 zero write keeps status");
    wr(16'hAFE1, 32'hFF);
    rd_expect(16'hAFE0, 32'h02, "R3 hi-byte clear leaves lo");
    rd_expect(16'hAFE1, 32'h00, "R3 hi byte");
    wr(16'hAFE0, 32'h02);
    rd_expect(16'hAFE0, 32'h00, "R3 bit1 cleared");

    wr(16'hAFE2, 32'h00);
    hp(1'b1, 5'd0);
    idle(2);
    chk("R6 no irq when disabled", irq_count, 2);
    rd_expect(16'hAFE0, 32'h02, "R5 status set while disabled");
    rd_expect(16'hAE00, 32'h1, "R5 inserted slot 0");

    // same-cycle clear and hotplug
    @(posedge clk); #1; clear_inputs();
    bus_sel = 1; bus_we = 1; bus_addr = 16'hAFE0; bus_wdata = 32'h02;
    hp_req = 1; hp_insert = 1; hp_slot = 5'd3;
    idle(1);
    rd_expect(16'hAFE0, 32'h02, "R11 hotplug wins over clear");
    rd_expect(16'hAE00, 32'h8, "R11 inserted slot 3");

    // enable cleared in the request cycle: pulse still follows old value
    wr(16'hAFE2, 32'h02);
    @(posedge clk); #1; clear_inputs();
    bus_sel = 1; bus_we = 1; bus_addr = 16'hAFE2; bus_wdata = 32'h00;
    hp_req = 1; hp_insert = 1; hp_slot = 5'd7;
    idle(2);
    chk("R6 pre-write enable used", irq_count, 3);
    rd_expect(16'hAFE2, 32'h00, "R4 enable lo cleared");

    wr(16'hAE00, 32'hFFFFFFFF);
    rd_expect(16'hAE00, 32'h80, "R7 slot window write ignored");
    wr(16'hAE04, 32'h0000FFFF);
    rd_expect(16'hAE04, 32'h0, "R7 removed map write ignored");

    rd_expect(16'hAE08, 32'h0, "R8 eject reads zero");
    rd_expect(16'hAE0B, 32'h0, "R8 eject top byte reads zero");

    wr(16'hAE08, 32'h000000A0);
    idle(2);
    chk("R9 eject strobe count", eject_count, 1);
    chk("R9 eject lowest bit 5", last_eject, 5);
    wr(16'hAE08, 32'h80000000);
    idle(2);
    chk("R9 eject slot 31", last_eject, 31);
    wr(16'hAE0A, 32'hFFFFFFFF);
    idle(2);
    chk("R9 eject slot 0", last_eject, 0);
    wr(16'hAE08, 32'h0);
    idle(2);
    chk("R10 zero eject no strobe", eject_count, 3);

    wr(16'hAFE4, 32'hFF);
    rd_expect(16'hAFE4, 32'h0, "R12 unmapped read");
    rd_expect(16'hAFE0, 32'h02, "R12 status unchanged");
    wr(16'h1234, 32'hFFFFFFFF);
    rd_expect(16'hAE00, 32'h80, "R12 bitmap unchanged");
    chk("R12 no stray strobe", eject_count, 3);

    @(posedge clk); #1; clear_inputs(); rst_n = 0;
    idle(2);
    rst_n = 1;
    rd_expect(16'hAFE0, 32'h0, "R1 status cleared by reset");
    rd_expect(16'hAE00, 32'h0, "R1 inserted cleared by reset");
    rd_expect(16'hAFE3, 32'h0, "R1 enable hi cleared by reset");
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule